// File: doc/BRIEF.md
# Three-Key Sequence Door Lock Controller

This controller watches a two-button keypad and pulses an unlock signal when the keys B, A, B are pressed in that order. Key inputs are synchronous to the clock. A key-valid bit qualifies two key-identity bits. The controller also drives a 4-bit count of the keys pressed in the current attempt. An external display decoder shows this count.

The controller is a Moore machine with six named states:

- `ST_REST` (count 0)
- `ST_OK1` (count 1)
- `ST_OK2` (count 2)
- `ST_OPEN` (count 3, unlock high)
- `ST_ERR1` (count 1)
- `ST_ERR2` (count 2)

A wrong key does not end the attempt at once. The machine moves onto the error path, which keeps counting presses so that a failed attempt still uses three keys before the lock returns to rest. The one exception is a wrong third key, which returns to rest at once.

The named transitions are:

- **Rest:** `ST_REST` stays on no key. It goes to `ST_OK1` on B and to `ST_ERR1` on any other key.
- **First good key:** `ST_OK1` stays on no key. It goes to `ST_OK2` on A and to `ST_ERR2` on any other key.
- **Second good key:** `ST_OK2` stays on no key. It goes to `ST_OPEN` on B and to `ST_REST` on any other key.
- **Open:** `ST_OPEN` always goes to `ST_REST`.
- **First error:** `ST_ERR1` stays on no key and goes to `ST_ERR2` on any key.
- **Second error:** `ST_ERR2` stays on no key and goes to `ST_REST` on any key.

The encodings 110 and 111 are not used as states. If the state register ever holds one of them, the machine shows a count of 0 with unlock low and moves to `ST_REST` on the next clock.

Top module: `door_seq_lock`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the machine in `ST_REST`, with `press_count` = 0 and `unlock` = 0. This holds even in the middle of an attempt.
- R2: Keys are decoded as follows, with `key_valid`, `key_a`, `key_b` written in that order:
  - `key_valid` = 0 means no key, whatever `key_a` and `key_b` are.
  - 1,1,0 is key A.
  - 1,0,1 is key B.
  - 1,1,1 and 1,0,0 are wrong keys.
- R3: The key sequence B, A, B gives `press_count` values 1, 2, 3 in the cycles after each accepted key. `unlock` is high together with count 3.
- R4: `unlock` stays high for exactly one cycle. The next clock returns the machine to count 0 whatever the input is, with or without a key.
- R5: With no key pressed, every state except `ST_OPEN` holds, and `press_count` is unchanged. This includes `ST_OK2`.
- R6: A first key other than B leads to count 1. Any second key then gives count 2. Any third key then gives count 0. `unlock` stays low throughout.
- R7: A second key other than A, after a correct first key, leads to count 2. The next key of any kind returns to count 0 without unlock.
- R8: A third key other than B, after a correct B, A, returns to count 0 at once without unlock.
- R9: `press_count` never exceeds 3. `unlock` is high only while the count is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | A key is pressed this cycle |
| key_a | input | 1 | Identity bit for key A |
| key_b | input | 1 | Identity bit for key B |
| unlock | output | 1 | One-cycle unlock pulse |
| press_count | output | 4 | Keys pressed in the current attempt, 0 to 3 |

## Verification
The bench holds the machine in the middle of a sequence with idle cycles, including in `ST_OK2`. A design that dropped back to rest there would lose a correct attempt.

It sends a wrong key at each of the three positions and checks each path:

- A design that reset the count on the first error would return to zero too early.
- A design that let the error path reach count 3 would unlock wrongly.

Illegal key codes, with both identity bits set or neither set, must count as wrong keys, and key bits with `key_valid` low must be ignored. The bench also checks that the unlock pulse ends after one cycle even with no key pressed, since a design that held `ST_OPEN` on an idle input would stay unlocked.

// File: rtl/door_seq_pkg.sv
package door_seq_pkg;

    typedef enum logic [2:0] {
        ST_REST = 3'b000,
        ST_OK1  = 3'b001,
        ST_OK2  = 3'b010,
        ST_OPEN = 3'b011,
        ST_ERR1 = 3'b100,
        ST_ERR2 = 3'b101
    } lock_state_e;

    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_A    = 2'd1,
        KEY_B    = 2'd2,
        KEY_BAD  = 2'd3
    } key_kind_e;

endpackage

// File: rtl/door_key_classify.sv
module door_key_classify
    import door_seq_pkg::*;
(
    input  logic      key_valid,
    input  logic      key_a,
    input  logic      key_b,
    output key_kind_e kind
);

    always_comb begin
        if (!key_valid) begin
            kind = KEY_NONE;
        end else if (key_a && !key_b) begin
            kind = KEY_A;
        end else if (key_b && !key_a) begin
            kind = KEY_B;
        end else begin
            kind = KEY_BAD;
        end
    end

endmodule

// File: rtl/door_next_state.sv
module door_next_state
    import door_seq_pkg::*;
(
    input  lock_state_e cur,
    input  key_kind_e   kind,
    output lock_state_e nxt
);

    logic pressed;
    assign pressed = (kind != KEY_NONE);

    always_comb begin
        nxt = ST_REST;
        unique case (cur)
            ST_REST: begin
                if (!pressed)            nxt = ST_REST;
                else if (kind == KEY_B)  nxt = ST_OK1;
                else                     nxt = ST_ERR1;
            end
            ST_OK1: begin
                if (!pressed)            nxt = ST_OK1;
                else if (kind == KEY_A)  nxt = ST_OK2;
                else                     nxt = ST_ERR2;
            end
            ST_OK2: begin
                if (!pressed)            nxt = ST_OK2;
                else if (kind == KEY_B)  nxt = ST_OPEN;
                else                     nxt = ST_REST;
            end
            ST_OPEN: nxt = ST_REST;
            ST_ERR1: nxt = pressed ? ST_ERR2 : ST_ERR1;
            ST_ERR2: nxt = pressed ? ST_REST : ST_ERR2;
            default: nxt = ST_REST;
        endcase
    end

endmodule

// File: rtl/door_outputs.sv
module door_outputs
    import door_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  lock_state_e      cur,
    output logic             unlock,
    output logic [CNT_W-1:0] press_count
);

    localparam logic [CNT_W-1:0] CNT_ZERO  = CNT_W'(0);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_THREE = CNT_W'(3);

    always_comb begin
        unlock      = 1'b0;
        press_count = CNT_ZERO;
        unique case (cur)
            ST_REST: press_count = CNT_ZERO;
            ST_OK1:  press_count = CNT_ONE;
            ST_OK2:  press_count = CNT_TWO;
            ST_OPEN: begin
                press_count = CNT_THREE;
                unlock      = 1'b1;
            end
            ST_ERR1: press_count = CNT_ONE;
            ST_ERR2: press_count = CNT_TWO;
            default: begin
                press_count = CNT_ZERO;
                unlock      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/door_seq_lock.sv
module door_seq_lock
    import door_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic             key_a,
    input  logic             key_b,
    output logic             unlock,
    output logic [CNT_W-1:0] press_count
);

    key_kind_e   kind;
    lock_state_e state_q;
    lock_state_e state_d;

    door_key_classify u_classify (
        .key_valid (key_valid),
        .key_a     (key_a),
        .key_b     (key_b),
        .kind      (kind)
    );

    door_next_state u_next (
        .cur  (state_q),
        .kind (kind),
        .nxt  (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_d;
        end
    end

    door_outputs #(
        .CNT_W (CNT_W)
    ) u_out (
        .cur         (state_q),
        .unlock      (unlock),
        .press_count (press_count)
    );

endmodule

// File: rtl/door_seq_lock_chk.sv
module door_seq_lock_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             key_valid,
    input logic             key_a,
    input logic             key_b,
    input logic             unlock,
    input logic [CNT_W-1:0] press_count
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (press_count == CNT_W'(0) && !unlock));

    // R4
    unlock_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |=> (!unlock && press_count == CNT_W'(0)));

    // R5
    hold_no_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!key_valid && !unlock) |=> $stable(press_count));

    // R3
    open_needs_b_chk: assert property (@(posedge clk) disable iff (rst)
        (press_count == CNT_W'(2) && !(key_valid && key_b && !key_a)) |=> !unlock);

    // R6
    wrong_first_chk: assert property (@(posedge clk) disable iff (rst)
        (press_count == CNT_W'(0) && key_valid && !(key_b && !key_a))
            |=> (press_count == CNT_W'(1) && !unlock));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (press_count <= CNT_W'(3)) && (!unlock || press_count == CNT_W'(3)));

endmodule

bind door_seq_lock door_seq_lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .key_valid   (key_valid),
    .key_a       (key_a),
    .key_b       (key_b),
    .unlock      (unlock),
    .press_count (press_count)
);

// File: tb/tb_door_seq_lock.sv
module tb_door_seq_lock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic       key_a = 1'b0;
    logic       key_b = 1'b0;
    logic       unlock;
    logic [3:0] press_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    door_seq_lock #(.CNT_W(4)) dut (
        .clk         (clk),
        .rst         (rst),
        .key_valid   (key_valid),
        .key_a       (key_a),
        .key_b       (key_b),
        .unlock      (unlock),
        .press_count (press_count)
    );

    task automatic expect_out(input int cnt, input bit unl, input string req);
        checks++;
        if (press_count !== 4'(cnt) || unlock !== unl) begin
            fails++;
            $display("FAIL %s: count=%0d unlock=%0b expected count=%0d unlock=%0b",
                     req, press_count, unlock, cnt, unl);
        end
    endtask

    // Drive one cycle of input, then sample just after the edge that consumes it.
    task automatic step(input bit k, input bit a, input bit b);
        @(negedge clk);
        key_valid = k;
        key_a     = a;
        key_b     = b;
        @(posedge clk);
        #1;
        key_valid = 1'b0;
        key_a     = 1'b0;
        key_b     = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_out(0, 1'b0, "R1 reset");
        step(1, 0, 1);
        step(1, 1, 0);
        expect_out(2, 1'b0, "R1 pre-reset");
        do_reset();
        expect_out(0, 1'b0, "R1 mid-attempt reset");
    endtask

    task automatic t_good_sequence();
        step(1, 0, 1); expect_out(1, 1'b0, "R3 first B");
        step(1, 1, 0); expect_out(2, 1'b0, "R3 then A");
        step(1, 0, 1); expect_out(3, 1'b1, "R3 unlock");
        step(0, 0, 0); expect_out(0, 1'b0, "R4 pulse ends on idle");
    endtask

    task automatic t_hold();
        step(1, 0, 1);
        step(0, 0, 0); expect_out(1, 1'b0, "R5 hold OK1");
        step(0, 1, 1); expect_out(1, 1'b0, "R5 hold OK1 bits ignored");
        step(1, 1, 0);
        step(0, 0, 0); expect_out(2, 1'b0, "R5 hold OK2");
        step(0, 0, 0); expect_out(2, 1'b0, "R5 hold OK2 again");
        step(1, 0, 1); expect_out(3, 1'b1, "R9 open after hold");
        step(1, 1, 0); expect_out(0, 1'b0, "R4 pulse ends on key");
    endtask

    task automatic t_wrong_first();
        step(1, 1, 0); expect_out(1, 1'b0, "R6 wrong first");
        step(0, 0, 0); expect_out(1, 1'b0, "R5 hold ERR1");
        step(1, 0, 1); expect_out(2, 1'b0, "R6 second press");
        step(0, 0, 0); expect_out(2, 1'b0, "R5 hold ERR2");
        step(1, 0, 1); expect_out(0, 1'b0, "R6 third press ends");
    endtask

    task automatic t_wrong_second();
        step(1, 0, 1);
        step(1, 0, 1); expect_out(2, 1'b0, "R7 wrong second");
        step(1, 0, 1); expect_out(0, 1'b0, "R7 back to rest");
    endtask

    task automatic t_wrong_third();
        step(1, 0, 1);
        step(1, 1, 0);
        step(1, 1, 0); expect_out(0, 1'b0, "R8 wrong third");
    endtask

    task automatic t_encoding();
        step(0, 0, 1); expect_out(0, 1'b0, "R2 key bits without valid");
        step(1, 1, 1); expect_out(1, 1'b0, "R2 both bits is wrong key");
        step(1, 0, 0); expect_out(2, 1'b0, "R2 no bits is a press");
        step(1, 1, 0); expect_out(0, 1'b0, "R2 ends error path");
        step(1, 0, 0); expect_out(1, 1'b0, "R2 empty code wrong first");
        step(1, 0, 1);
        step(1, 0, 1); expect_out(0, 1'b0, "R2 error path completes");
        step(1, 0, 1);
        step(1, 1, 1); expect_out(2, 1'b0, "R2 both bits wrong second");
        step(1, 0, 1); expect_out(0, 1'b0, "R7 after bad code");
    endtask

    initial begin
        #(10 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: count=%0d unlock=%0b expected run to finish",
                     press_count, unlock);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_good_sequence();
        t_hold();
        t_wrong_first();
        t_wrong_second();
        t_wrong_third();
        t_encoding();
        t_good_sequence();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule